// File: doc/BRIEF.md
# Serial PHY Management Master

This block lets a host reach the management registers of an Ethernet PHY over the two-wire serial management bus, using clause-22 frames. The host works through four 32-bit registers. A write to the frame register loads a complete, pre-encoded 32-bit management word: start code, operation code, PHY address, register address, turnaround and data. That write also launches one serial transaction.

The block first shifts out a preamble of ones. It then sends the word, most significant bit first, on the data line and toggles the management clock. On a read it releases the data line, samples the PHY's 16-bit reply and places it in the low half of the frame register. When the transaction ends, a sticky completion flag is set, and the host clears it by writing one to it.

A speed register sets how many system clocks make up each half period of the management clock. A self-clearing control bit returns the whole block to its reset state.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, all four registers read zero, the management clock is low and the data-line output enable is low. Register offsets are 0 = frame, 1 = event, 2 = speed, 3 = control.
- R2: A write to offset 0 while idle, with a nonzero speed field, stores the word and starts exactly one transaction. Bit 1 of the event register reads 1 while a transaction is in progress.
- R3: A transaction is 64 bit times: 32 ones, then frame bits 31 down to 0. A bit changes only when the management clock falls, and the first bit is driven while the clock is still low.
- R4: The management clock idles low. During a transaction it spends S system clocks low, then S high, for each bit, where S is the speed field captured at launch. The clock is low again on the cycle the transaction ends, 128·S cycles after launch.
- R5: When frame bits 29:28 equal 2'b10 (read), the output enable is low from bit time 47 (the second turnaround bit) through bit time 63. Otherwise it is high for the whole transaction. It is always low when idle.
- R6: On a read, the data line is sampled at the rising clock edge of bit times 48 to 63, most significant bit first. At completion the samples replace frame bits 15:0, and bits 31:16 are kept. A write transaction leaves the frame register unchanged.
- R7: Event bit 0 is set when a transaction ends. Writing 1 to it clears it, and writing 0 has no effect. If completion and a clear fall on the same cycle, the bit ends up set.
- R8: A write to offset 0 while a transaction is in progress is ignored: the frame register keeps its value and no further transaction starts.
- R9: The speed field is bits 6:1 of offset 2. Reads return bit 0 and bits 31:7 as zero. With the field at zero, a frame write stores the word but starts no transaction, and the clock stays low.
- R10: Writing 1 to bit 0 of offset 3 makes that bit read 1 until the next clock edge. At that edge every register returns to its reset value, any transaction in progress is abandoned, and the bit reads 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read offset |
| rd_data | output | 32 | Register read data (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
The assertions take three things for granted:
- Only one register write happens per cycle.
- The speed field is not zero at the moment a transaction launches.
- The PHY changes the data line only away from the rising clock edge.

The stimulus respects all three. Writes go through a single write task, one per call. Every launch that is expected to start a transaction follows a nonzero speed write. The bench's PHY model updates the data input on the falling system clock edge, using the bit time the reference model has computed. Completion and clear are made to coincide by waiting until the model reports one cycle left before the end.

// File: rtl/mdio_pkg.sv
// Package: shared constants for the serial management master.
// Assumes clause-22 framing: 32-bit preamble followed by a 32-bit word.
package mdio_pkg;
    localparam int FRAME_W    = 32;
    localparam int PRE_W      = 32;
    localparam int STREAM_W   = PRE_W + FRAME_W;
    localparam int DATA_W     = 16;
    localparam int IDX_W      = $clog2(STREAM_W);
    // bit time at which a read releases the line (second turnaround bit)
    localparam int RD_RELEASE = STREAM_W - DATA_W - 1;
    localparam int RD_FIRST   = STREAM_W - DATA_W;
    localparam logic [1:0] OP_READ = 2'b10;

    typedef enum logic [1:0] {
        REG_FRAME = 2'd0,
        REG_EVENT = 2'd1,
        REG_SPEED = 2'd2,
        REG_CTRL  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/mdio_clkgen.sv
// Module: management clock generator.
// Produces a clock with DIV system clocks per half period while run is high,
// plus one-cycle strobes marking the edge on which it rises or falls.
// Assumes div is nonzero whenever run is high. Idles low.
module mdio_clkgen #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);
    logic [DIV_W-1:0] cnt_q;
    logic             wrap;

    assign wrap      = run && (cnt_q == div - 1'b1);
    assign rise_tick = wrap && !mdc;
    assign fall_tick = wrap && mdc;

    // half-period counter and clock toggle
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_engine.sv
// Module: frame serializer for one management transaction.
// On start (when idle) shifts out preamble plus frame MSB first, changing
// bits on clock fall, releasing the line for reads and capturing the reply
// on clock rise. Assumes div_in is nonzero when start is asserted.
module mdio_engine
    import mdio_pkg::*;
#(
    parameter int DIV_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic [DIV_W-1:0]   div_in,
    input  logic               mdio_i,
    output logic               busy,
    output logic               mdc,
    output logic               mdio_o,
    output logic               mdio_oe,
    output logic               done_pulse,
    output logic               rd_done,
    output logic [DATA_W-1:0]  rd_data
);
    logic [STREAM_W-1:0] shreg_q;
    logic [IDX_W-1:0]    idx_q;
    logic                is_rd_q;
    logic [DIV_W-1:0]    div_q;
    logic                rise_tick;
    logic                fall_tick;

    mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .div       (div_q),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    assign done_pulse = busy && fall_tick && (idx_q == IDX_W'(STREAM_W - 1));
    assign rd_done    = done_pulse && is_rd_q;
    assign mdio_o     = shreg_q[STREAM_W-1];
    assign mdio_oe    = busy && !(is_rd_q && (idx_q >= IDX_W'(RD_RELEASE)));

    // launch, shift on falling clock, capture on rising clock, finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            shreg_q <= '0;
            idx_q   <= '0;
            is_rd_q <= 1'b0;
            div_q   <= '0;
            rd_data <= '0;
        end else if (start && !busy) begin
            busy    <= 1'b1;
            shreg_q <= {{PRE_W{1'b1}}, frame_in};
            idx_q   <= '0;
            is_rd_q <= (frame_in[FRAME_W-3 -: 2] == OP_READ);
            div_q   <= div_in;
        end else if (busy) begin
            if (rise_tick && is_rd_q && (idx_q >= IDX_W'(RD_FIRST))) begin
                rd_data <= {rd_data[DATA_W-2:0], mdio_i};
            end
            if (fall_tick) begin
                shreg_q <= {shreg_q[STREAM_W-2:0], 1'b1};
                if (idx_q == IDX_W'(STREAM_W - 1)) begin
                    busy <= 1'b0;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mdio_mgmt_master.sv
// Module: register-mapped serial management master (top).
// Holds frame, event, speed and control registers, and launches the engine
// on a frame write. Assumes at most one register write per cycle; reads are
// combinational from rd_addr.
module mdio_mgmt_master
    import mdio_pkg::*;
#(
    parameter int DIV_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [FRAME_W-1:0] wr_data,
    input  logic [1:0]         rd_addr,
    output logic [FRAME_W-1:0] rd_data,
    output logic               mdc,
    output logic               mdio_o,
    output logic               mdio_oe,
    input  logic               mdio_i
);
    logic [FRAME_W-1:0] frame_q;
    logic               done_q;
    logic [DIV_W-1:0]   speed_q;
    logic               srst_q;
    logic               core_rst_n;
    logic               busy_w;
    logic               done_pulse;
    logic               rd_done;
    logic [DATA_W-1:0]  reply;
    logic               wr_frame;
    logic               start;

    assign core_rst_n = rst_n && !srst_q;
    assign wr_frame   = wr_en && (wr_addr == REG_FRAME);
    assign start      = wr_frame && !busy_w && (speed_q != '0);

    mdio_engine #(.DIV_W(DIV_W)) u_engine (
        .clk        (clk),
        .rst_n      (core_rst_n),
        .start      (start),
        .frame_in   (wr_data),
        .div_in     (speed_q),
        .mdio_i     (mdio_i),
        .busy       (busy_w),
        .mdc        (mdc),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe),
        .done_pulse (done_pulse),
        .rd_done    (rd_done),
        .rd_data    (reply)
    );

    // self-clearing soft reset request
    always_ff @(posedge clk) begin
        if (!rst_n || srst_q) begin
            srst_q <= 1'b0;
        end else if (wr_en && (wr_addr == REG_CTRL) && wr_data[0]) begin
            srst_q <= 1'b1;
        end
    end

    // host-visible registers
    always_ff @(posedge clk) begin
        if (!core_rst_n) begin
            frame_q <= '0;
            done_q  <= 1'b0;
            speed_q <= '0;
        end else begin
            if (rd_done) begin
                frame_q[DATA_W-1:0] <= reply;
            end else if (wr_frame && !busy_w) begin
                frame_q <= wr_data;
            end
            if (done_pulse) begin
                done_q <= 1'b1;
            end else if (wr_en && (wr_addr == REG_EVENT) && wr_data[0]) begin
                done_q <= 1'b0;
            end
            if (wr_en && (wr_addr == REG_SPEED)) begin
                speed_q <= wr_data[DIV_W:1];
            end
        end
    end

    // read multiplexer
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            REG_FRAME: rd_data = frame_q;
            REG_EVENT: rd_data = {{(FRAME_W-2){1'b0}}, busy_w, done_q};
            REG_SPEED: rd_data = {{(FRAME_W-DIV_W-1){1'b0}}, speed_q, 1'b0};
            default:   rd_data = {{(FRAME_W-1){1'b0}}, srst_q};
        endcase
    end
endmodule

// File: rtl/mdio_master_chk.sv
// Module: property checker for the management master, bound to the top.
// Assumes one register write per cycle and a nonzero speed at launch.
module mdio_master_chk #(
    parameter int DIV_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             mdc,
    input logic             mdio_o,
    input logic             done_q,
    input logic [DIV_W-1:0] speed_q,
    input logic             srst_q
);
    AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc); // R4
    AST_DATA_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> $stable(mdio_o)); // R3
    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(srst_q)) |-> done_q); // R7
    AST_SPEED_ZERO_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (speed_q == '0)) |=> !busy); // R9
    AST_SRST_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        srst_q |=> !srst_q); // R10
endmodule

bind mdio_mgmt_master mdio_master_chk #(.DIV_W(DIV_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy_w),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .done_q  (done_q),
    .speed_q (speed_q),
    .srst_q  (srst_q)
);

// File: tb/mdio_mgmt_master_tb.sv
module mdio_mgmt_master_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int failures = 0;
    bit chk_on = 1'b0;

    // behavioural reference state
    bit          m_busy, m_rd, m_done, m_rst;
    int          m_t, m_S;
    logic [31:0] m_frame, m_launch;
    logic [5:0]  m_speed;
    logic [15:0] phy_reply = 16'h0000;
    bit          m_fin, m_was;

    always #4 clk = ~clk;

    mdio_mgmt_master u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // reference model: advances one system clock per edge
    always @(posedge clk) begin
        if (!rst_n || m_rst) begin
            m_busy = 0; m_rd = 0; m_done = 0; m_rst = 0; m_t = 0; m_S = 1;
            m_frame = '0; m_launch = '0; m_speed = '0;
        end else begin
            m_was = m_busy;
            m_fin = 0;
            if (m_busy) begin
                m_t++;
                if (m_t == 128 * m_S) begin
                    m_busy = 0; m_fin = 1; m_done = 1;
                    if (m_rd) m_frame[15:0] = phy_reply;
                end
            end
            if (wr_en) begin
                case (wr_addr)
                    2'd0: if (!m_was) begin
                        m_frame = wr_data;
                        if (m_speed != 0) begin
                            m_busy = 1; m_t = 0; m_S = m_speed;
                            m_rd = (wr_data[29:28] == 2'b10); m_launch = wr_data;
                        end
                    end
                    2'd1: if (wr_data[0] && !m_fin) m_done = 0;
                    2'd2: m_speed = wr_data[6:1];
                    default: if (wr_data[0]) m_rst = 1;
                endcase
            end
        end
    end

    // per-cycle comparison of pins and PHY reply drive
    always @(negedge clk) begin
        int idx;
        logic e_mdc, e_oe, e_bit;
        idx   = m_busy ? m_t / (2 * m_S) : 0;
        e_mdc = m_busy ? (((m_t / m_S) % 2) == 1) : 1'b0;
        e_oe  = m_busy && !(m_rd && idx >= 47);
        e_bit = (idx < 32) ? 1'b1 : m_launch[63 - idx];
        mdio_i <= (m_busy && m_rd && idx >= 48) ? phy_reply[63 - idx] : 1'b1;
        if (chk_on) begin
            checks++;
            if (mdc !== e_mdc || mdio_oe !== e_oe || (e_oe && mdio_o !== e_bit)) begin
                failures++;
                $display("FAIL R3/R4/R5 t=%0d actual mdc=%b oe=%b o=%b expected mdc=%b oe=%b o=%b",
                         m_t, mdc, mdio_oe, mdio_o, e_mdc, e_oe, e_bit);
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic chk(input logic [1:0] a, input logic [31:0] exp, input string tag);
        rd_addr = a;
        #1;
        checks++;
        if (rd_data !== exp) begin
            failures++;
            $display("FAIL %s offset=%0d actual=%h expected=%h", tag, a, rd_data, exp);
        end
    endtask

    task automatic wait_idle();
        while (m_busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [31:0] mkframe(input logic [1:0] op, input logic [4:0] pa,
                                            input logic [4:0] ra, input logic [15:0] d);
        return {2'b01, op, pa, ra, 2'b10, d};
    endfunction

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R2 actual=hung expected=finished");
        report();
    end

    initial begin
        logic [31:0] f;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk_on = 1;
        // R1 reset state
        for (int a = 0; a < 4; a++) chk(2'(a), 32'h0, "R1 reset");

        // R9 speed field position
        wr(2'd2, 32'hFFFF_FF85);
        chk(2'd2, 32'h0000_0004, "R9 speed readback");

        // R2/R6 write transaction at S=2, R8 ignored write while busy
        f = mkframe(2'b01, 5'd3, 5'd9, 16'hA5C3);
        wr(2'd0, f);
        chk(2'd1, 32'h2, "R2 busy set");
        repeat (20) @(negedge clk);
        wr(2'd0, 32'h6000_0000);
        chk(2'd0, f, "R8 frame kept while busy");
        wait_idle();
        chk(2'd0, f, "R6 write leaves frame");
        chk(2'd1, 32'h1, "R7 done set, R8 no second launch");

        // R7 write-0 no effect, write-1 clears
        wr(2'd1, 32'h0);
        chk(2'd1, 32'h1, "R7 write zero keeps");
        wr(2'd1, 32'hFFFF_FFFF);
        chk(2'd1, 32'h0, "R7 write one clears");

        // R5/R6 read transaction at S=1
        wr(2'd2, 32'd2);
        phy_reply = 16'hBEEF;
        f = mkframe(2'b10, 5'd1, 5'd2, 16'h0000);
        wr(2'd0, f);
        wait_idle();
        chk(2'd0, {f[31:16], 16'hBEEF}, "R6 read reply S1");

        // R5/R6 read at S=3, R7 completion and clear on same edge
        wr(2'd2, 32'd6);
        phy_reply = 16'h1234;
        f = mkframe(2'b10, 5'd31, 5'd17, 16'hFFFF);
        wr(2'd0, f);
        while (!(m_busy && m_t == 128 * m_S - 1)) @(negedge clk);
        wr_en = 1; wr_addr = 2'd1; wr_data = 32'h1;
        @(negedge clk);
        wr_en = 0;
        chk(2'd1, 32'h1, "R7 set wins over clear");
        chk(2'd0, {f[31:16], 16'h1234}, "R6 read reply S3");
        wait_idle();

        // R9 speed zero blocks launch but stores word
        wr(2'd2, 32'h0);
        wr(2'd0, 32'h5555_AAAA);
        repeat (10) @(negedge clk);
        chk(2'd1, 32'h1, "R9 no launch at speed zero");
        chk(2'd0, 32'h5555_AAAA, "R9 frame stored");

        // R10 soft reset mid-transaction
        wr(2'd2, 32'd4);
        wr(2'd0, mkframe(2'b01, 5'd7, 5'd7, 16'h0F0F));
        repeat (30) @(negedge clk);
        @(negedge clk);
        wr_en = 1; wr_addr = 2'd3; wr_data = 32'h1;
        @(negedge clk);
        wr_en = 0;
        chk(2'd3, 32'h1, "R10 control bit set");
        @(negedge clk);
        chk(2'd3, 32'h0, "R10 control self-clear");
        chk(2'd0, 32'h0, "R10 frame reset");
        chk(2'd1, 32'h0, "R10 event reset");
        chk(2'd2, 32'h0, "R10 speed reset");
        repeat (5) @(negedge clk);
        report();
    end
endmodule